// File: doc/BRIEF.md
# Pin Port Register Block with Per-Pin Masked Writes

This block is the register file of one eight-pin general-purpose I/O port. Software reaches it over a plain 32-bit register bus (address, write strobe, write data, combinational read data). For every pin it holds three control bits: a select bit that puts the pin under I/O control, a drive-enable bit and a drive-level bit. It also samples the pin inputs through a synchronizer so that software can read them.

Each control register has two write paths. The direct path replaces the whole register. The masked path updates only chosen pins. In a masked write the upper half of the used data bits says which pins change, and the lower half gives their new levels. One pin can therefore be switched with a single bus write, with no read-modify-write that could race another agent.

The pad side is three vectors: the level to drive, the drive enable, and the sampled input. A pin drives only when its select bit and its drive-enable bit are both set. The drive level can be loaded before the drive is enabled, so the pin comes up at the intended level.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset all control registers are 0. `pad_oe` and `pad_out` are 0, and reads of 0x00, 0x10 and 0x20 return 0.
- R2: A write to 0x00 (select), 0x10 (drive enable) or 0x20 (drive level) loads data bits [7:0] into that register. A read of the same address returns the register in bits [7:0] and zeros above.
- R3: A write to a masked alias changes pin n only if data bit 8+n is 1, and then loads data bit n. Pins whose bit 8+n is 0 keep their state. The aliases are 0x80 (select), 0x90 (drive enable) and 0xA0 (drive level).
- R4: A read of any masked alias address (0x80, 0x90, 0xA0) returns 0.
- R5: A read of 0x30 returns `pad_in` as it stood before the clock edge two edges earlier, through a two-stage synchronizer that resets to 0.
- R6: `pad_oe[n]` is 1 exactly when select bit n and drive-enable bit n are both 1. `pad_out[n]` equals drive-level bit n while `pad_oe[n]` is 1, and is 0 otherwise.
- R7: A write to 0x30 or to an unmapped address changes no register.
- R8: A drive level loaded while the pin's drive enable is 0 does not reach `pad_out`. It appears on `pad_out` right after the edge that sets the drive enable.
- R9: A read of a register in the same cycle as a write to it returns the value from before the write. The new value is readable after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pad_in | input | PINS (8) | Pin levels as seen at the pads |
| pad_out | output | PINS (8) | Level driven on each pin |
| pad_oe | output | PINS (8) | Drive enable for each pin |

## Verification
A write and a read can hit the same register in one cycle. The same cycle can also carry a new `pad_in` pattern while the synchronized input is being read. The bench drives the write address with a read of that same address, and changes the pin inputs on cycles that read 0x30. It judges the read data against a reference model that still holds the state from before the edge. Right after the edge it compares the pad outputs against the updated model.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // Which storage element an address selects
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_CFG  = 3'd1,
      SEL_OE   = 3'd2,
      SEL_OUT  = 3'd3,
      SEL_IN   = 3'd4
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e sel;
      logic     masked;
   } dec_t;

   localparam int unsigned NUM_CTL = 3;

   // Byte offsets of the direct registers; the aliases repeat them
   localparam int unsigned OFS_CFG = 'h00;
   localparam int unsigned OFS_OE  = 'h10;
   localparam int unsigned OFS_OUT = 'h20;
   localparam int unsigned OFS_IN  = 'h30;

   function automatic reg_sel_e ctl_sel(input int unsigned idx);
      case (idx)
         0:       return SEL_CFG;
         1:       return SEL_OE;
         default: return SEL_OUT;
      endcase
   endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_mask_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned ALIAS_OFS = 'h80
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int unsigned TOP_ADDR = ALIAS_OFS + OFS_OUT;

   if (ALIAS_OFS <= OFS_IN) begin : g_bad_alias
      $error("ALIAS_OFS must lie above the input register");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_width
      $error("ADDR_W too narrow for the alias window");
   end

   always_comb begin
      dec = '{sel: SEL_NONE, masked: 1'b0};
      if (addr == ADDR_W'(OFS_CFG))                dec.sel = SEL_CFG;
      else if (addr == ADDR_W'(OFS_OE))            dec.sel = SEL_OE;
      else if (addr == ADDR_W'(OFS_OUT))           dec.sel = SEL_OUT;
      else if (addr == ADDR_W'(OFS_IN))            dec.sel = SEL_IN;
      else if (addr == ADDR_W'(ALIAS_OFS + OFS_CFG)) begin
         dec.sel = SEL_CFG; dec.masked = 1'b1;
      end
      else if (addr == ADDR_W'(ALIAS_OFS + OFS_OE)) begin
         dec.sel = SEL_OE; dec.masked = 1'b1;
      end
      else if (addr == ADDR_W'(ALIAS_OFS + OFS_OUT)) begin
         dec.sel = SEL_OUT; dec.masked = 1'b1;
      end
   end

endmodule

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
   parameter int unsigned PINS   = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_direct,
   input  logic              wr_masked,
   input  logic [DATA_W-1:0] wdata,
   output logic [PINS-1:0]   q
);

   logic [PINS-1:0] lane_en;
   logic [PINS-1:0] lane_val;
   logic [PINS-1:0] merged;

   assign lane_en  = wdata[PINS +: PINS];
   assign lane_val = wdata[PINS-1:0];

   // Per-pin merge: enabled lanes take the new value, others hold
   for (genvar n = 0; n < PINS; n++) begin : g_lane
      assign merged[n] = lane_en[n] ? lane_val[n] : q[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= '0;
      else if (wr_direct) q <= lane_val;
      else if (wr_masked) q <= merged;
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned PINS   = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d,
   output logic [PINS-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [PINS-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int unsigned PINS        = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ALIAS_OFS   = 'h80,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe
);

   localparam int unsigned PAD_W = DATA_W - PINS;

   if (2 * PINS > DATA_W) begin : g_bad_pins
      $error("masked write needs 2*PINS data bits");
   end

   dec_t            dec;
   logic [PINS-1:0] ctl_q [NUM_CTL];
   logic [PINS-1:0] in_sync;
   logic [PINS-1:0] cfg_q, oe_q, out_q;
   logic [PINS-1:0] rd_sel;

   gpio_addr_decode #(
      .ADDR_W    (ADDR_W),
      .ALIAS_OFS (ALIAS_OFS)
   ) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
      logic hit;
      assign hit = bus_we && (dec.sel == ctl_sel(k));
      gpio_ctl_reg #(
         .PINS   (PINS),
         .DATA_W (DATA_W)
      ) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_direct (hit && !dec.masked),
         .wr_masked (hit && dec.masked),
         .wdata     (bus_wdata),
         .q         (ctl_q[k])
      );
   end

   assign cfg_q = ctl_q[0];
   assign oe_q  = ctl_q[1];
   assign out_q = ctl_q[2];

   gpio_in_sync #(
      .PINS   (PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   // Readback: aliases and unmapped addresses read as zero
   always_comb begin
      rd_sel = '0;
      if (!dec.masked) begin
         case (dec.sel)
            SEL_CFG: rd_sel = cfg_q;
            SEL_OE:  rd_sel = oe_q;
            SEL_OUT: rd_sel = out_q;
            SEL_IN:  rd_sel = in_sync;
            default: rd_sel = '0;
         endcase
      end
   end

   assign bus_rdata = {{PAD_W{1'b0}}, rd_sel};

   // Pad drive: only pins under I/O control with drive enabled
   assign pad_oe  = cfg_q & oe_q;
   assign pad_out = out_q & pad_oe;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int unsigned PINS        = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ALIAS_OFS   = 'h80,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [PINS-1:0]   pad_in,
   input logic [PINS-1:0]   pad_out,
   input logic [PINS-1:0]   pad_oe
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1: pads quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (pad_oe == '0 && pad_out == '0)
            else $error("pads active in reset");
      end
   end

   // R6: no level driven on a pin whose drive is off
   p_out_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R4: alias addresses read as zero
   p_alias_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ALIAS_OFS) || bus_addr == ADDR_W'(ALIAS_OFS + 'h10) ||
       bus_addr == ADDR_W'(ALIAS_OFS + 'h20)) |-> bus_rdata == '0);

   // R3: masked drive-enable write leaves unselected pins alone
   p_masked_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(ALIAS_OFS + 'h10)) |=>
      ((pad_oe ^ $past(pad_oe)) & ~$past(bus_wdata[2*PINS-1:PINS])) == '0);

   // R7: no write, or a write to the input register, moves no pad
   p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we || bus_addr == ADDR_W'('h30)) |=> $stable(pad_oe) && $stable(pad_out));

   // R5: input readback lags the pads by two edges
   if (SYNC_STAGES == 2) begin : g_sync_chk
      p_in_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && bus_addr == ADDR_W'('h30)) |->
         bus_rdata[PINS-1:0] == $past(pad_in, 2));
   end

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .PINS        (PINS),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .ALIAS_OFS   (ALIAS_OFS),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out;
   logic [7:0]  pad_oe;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference state
   int m_cfg = 0, m_oe = 0, m_out = 0, m_s1 = 0, m_s2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mask_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int model_read(input int a);
      case (a)
         'h00: return m_cfg;
         'h10: return m_oe;
         'h20: return m_out;
         'h30: return m_s2;
         default: return 0;
      endcase
   endfunction

   function automatic int merge(input int old, input int wd);
      int r = old;
      for (int n = 0; n < 8; n++)
         if (wd[8+n]) r[n] = wd[n];
      return r;
   endfunction

   // One bus cycle: read check before the edge, pad check after it
   task automatic cyc(input int a, input bit we, input int wd, input int pin,
                      input string tag);
      @(negedge clk);
      bus_addr = a[7:0]; bus_we = we; bus_wdata = wd; pad_in = pin[7:0];
      #1;
      check({tag, " read"}, int'(bus_rdata), model_read(a));
      @(posedge clk);
      m_s2 = m_s1; m_s1 = pin & 'hFF;
      if (we && rst_n) begin
         case (a)
            'h00: m_cfg = wd & 'hFF;
            'h10: m_oe  = wd & 'hFF;
            'h20: m_out = wd & 'hFF;
            'h80: m_cfg = merge(m_cfg, wd);
            'h90: m_oe  = merge(m_oe, wd);
            'hA0: m_out = merge(m_out, wd);
            default: ;
         endcase
      end
      #1;
      check({tag, " oe"},  int'(pad_oe),  m_cfg & m_oe);
      check({tag, " out"}, int'(pad_out), m_cfg & m_oe & m_out);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      #1;
      check("R1 oe in reset", int'(pad_oe), 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset contents
      cyc('h00, 0, 0, 0, "R1 cfg");
      cyc('h10, 0, 0, 0, "R1 oe");
      cyc('h20, 0, 0, 0, "R1 out");
      // R2: direct writes and readback (upper bits ignored)
      cyc('h00, 1, 'hFFFF_FF0F, 0, "R2 wr cfg");
      cyc('h10, 1, 'h0000_00A5, 0, "R2 wr oe");
      cyc('h20, 1, 'h1234_563C, 0, "R2 wr out");
      cyc('h00, 0, 0, 0, "R2 rd cfg");
      cyc('h10, 0, 0, 0, "R2 rd oe");
      cyc('h20, 0, 0, 0, "R6 gating");
      cyc('h00, 1, 'hFF, 0, "R6 cfg all");
      // R3: masked writes, several patterns
      cyc('hA0, 1, 'h0000_0301, 0, "R3 out pins0-1");
      cyc('hA0, 1, 'h0000_00FF, 0, "R3 no enables");
      cyc('h90, 1, 'h0000_F00F, 0, "R3 oe hi nibble");
      cyc('h80, 1, 'h0000_8100, 0, "R3 cfg pins0,7");
      cyc('h00, 0, 0, 0, "R3 rd cfg");
      cyc('h10, 0, 0, 0, "R3 rd oe");
      // R4: aliases read zero
      cyc('h80, 0, 0, 0, "R4 cfg alias");
      cyc('h90, 0, 0, 0, "R4 oe alias");
      cyc('hA0, 0, 0, 0, "R4 out alias");
      // R7: writes that must not land
      cyc('h30, 1, 'hFFFF_FFFF, 0, "R7 wr in");
      cyc('h44, 1, 'hFFFF_FFFF, 0, "R7 wr unmapped");
      cyc('h00, 0, 0, 0, "R7 rd cfg");
      cyc('h10, 0, 0, 0, "R7 rd oe");
      cyc('h20, 0, 0, 0, "R7 rd out");
      // R5: input synchronizer, pins change on read cycles
      cyc('h30, 0, 0, 'h5A, "R5 in a");
      cyc('h30, 0, 0, 'hC3, "R5 in b");
      cyc('h30, 0, 0, 'h01, "R5 in c");
      cyc('h30, 0, 0, 'hFF, "R5 in d");
      cyc('h30, 0, 0, 'h00, "R5 in e");
      cyc('h30, 0, 0, 'h00, "R5 in f");
      // R8: preload level with drive off, then enable drive
      cyc('h80, 1, 'h0000_4040, 0, "R8 cfg pin6");
      cyc('h90, 1, 'h0000_4000, 0, "R8 oe off pin6");
      cyc('hA0, 1, 'h0000_4040, 0, "R8 preload pin6");
      cyc('h90, 1, 'h0000_4040, 0, "R8 oe on pin6");
      // R9: read and write of one register in the same cycle
      cyc('h20, 1, 'h0000_0099, 0, "R9 same-cycle out");
      cyc('h20, 0, 0, 0, "R9 after out");
      cyc('h10, 1, 'h0000_0000, 0, "R9 same-cycle oe");
      cyc('h10, 0, 0, 0, "R9 after oe");
      // R1: reset clears everything again
      @(negedge clk); rst_n = 1'b0;
      m_cfg = 0; m_oe = 0; m_out = 0; m_s1 = 0; m_s2 = 0;
      #1;
      check("R1 oe after reset", int'(pad_oe), 0);
      check("R1 out after reset", int'(pad_out), 0);
      @(negedge clk); rst_n = 1'b1;
      cyc('h20, 0, 0, 0, "R1 out cleared");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule